// File: doc/BRIEF.md
# Byte/Word Data Memory Access Unit

This unit connects a 16-bit datapath to a data store split into two byte-wide banks. Both banks decode the same row index, and each has its own write enable. The datapath issues one access per cycle. Each access has a direction, a size (byte or word) and a 16-bit byte address. The unit works out which banks to write and steers the addressed byte down to bits 7:0 on a read. It also gives the load value already merged with the destination register and the size-scaled post-increment of a pointer.

Word accesses must use even addresses. An odd word address is flagged in the same cycle. A misaligned read still returns the word that holds the addressed byte. A misaligned write leaves both banks untouched. In both cases the unit captures the faulting address and direction and raises a single-cycle trap on the following clock. A separate combinational path widens the low byte of a register to 16 bits, either signed or unsigned. Addresses at or above the configured byte depth have no storage: they read as zero and ignore writes.

Top module: `bwmem_access_unit`

## Requirements
- R1: A byte read fetches the containing row, and `req_addr[0]` selects the byte: 0 gives the low bank, 1 gives the high bank. `rd_data` carries that byte in bits 7:0 with bits 15:8 zero.
- R2: A byte write stores `req_wdata[7:0]` only into the bank chosen by `req_addr[0]`. The other byte of that row keeps its value.
- R3: A word write at an even address stores `req_wdata[7:0]` in the low bank and `req_wdata[15:8]` in the high bank. A word read returns `{high, low}` of the row.
- R4: `addr_err` is 1 in the same cycle as a valid word access with `req_addr[0]`=1, and 0 for every other access.
- R5: A misaligned word read still returns on `rd_data` the word of the row at `req_addr` with bit 0 cleared.
- R6: A misaligned word write changes no memory byte.
- R7: After a cycle with `addr_err`=1, `trap_pulse` is 1 for exactly the next cycle. `fault_addr` takes the faulting address and `fault_write` takes the direction (1 = write). Both hold until the next fault.
- R8: `ptr_next` equals `ptr_in`+1 when `req_byte`=1 and `ptr_in`+2 otherwise, modulo 2^16.
- R9: On a byte read, `ld_result` is `{dst_in[15:8], selected byte}`. On a word read it equals the word read.
- R10: With `ext_sign`=1, `ext_out` is `ext_src[7:0]` with bit 7 copied into bits 15:8. With `ext_sign`=0, bits 15:8 are zero.
- R11: Addresses at or above `MEM_BYTES` read as zero and ignore writes.
- R12: A synchronous active-low reset clears `trap_pulse`, `fault_addr` and `fault_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte size, 0 = word size |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| dst_in | input | 16 | Current destination register value |
| ptr_in | input | 16 | Pointer to post-increment |
| ext_src | input | 16 | Register to widen |
| ext_sign | input | 1 | 1 = sign-extend, 0 = zero-extend |
| rd_data | output | 16 | Steered read data |
| ld_result | output | 16 | Destination value after the load |
| ptr_next | output | 16 | Post-incremented pointer |
| ext_out | output | 16 | Widened register value |
| addr_err | output | 1 | Misaligned word access this cycle |
| trap_pulse | output | 1 | One-cycle trap following a fault |
| fault_addr | output | 16 | Address of the most recent fault |
| fault_write | output | 1 | Direction of the most recent fault |

## Verification
The trap from one access and the detection of the next fault can fall in the same cycle. The sweeps provoke this by issuing odd word addresses back to back, so a new fault is flagged while the previous trap is still high. The bench judges the result cycle by cycle. `trap_pulse` must stay high for exactly as many cycles as there were consecutive faults. `fault_addr` and `fault_write` must follow the newest fault, and a misaligned write inside the run must not disturb the banks, which later reads confirm.

// File: rtl/bwmem_pkg.sv
// Package: shared widths and the access request record for the
// byte/word memory access unit. Assumes a 16-bit datapath of two bytes.
package bwmem_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        acc_size_e         size;
        logic [ADDR_W-1:0] addr;
    } acc_req_t;
endpackage

// File: rtl/bwmem_bank.sv
// Module: one byte-wide storage bank. Write is synchronous on the rising
// edge when we is high; read is asynchronous by row index. Contents are
// not reset; the caller guarantees the row indices are within ROWS.
module bwmem_bank #(
    parameter int ROWS  = 64,
    parameter int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rbyte
);
    logic [7:0] cells [ROWS];

    // Store the byte into the addressed row on a write enable.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[widx] <= wbyte;
        end
    end

    // Present the addressed row combinationally.
    always_comb begin
        rbyte = cells[ridx];
    end
endmodule

// File: rtl/bwmem_steer.sv
// Module: read steering, load merge and pointer step. Picks the addressed
// byte onto bits 7:0, merges byte loads into the destination, and scales
// the post-increment by access size. Assumes lo/hi come from the same row.
module bwmem_steer
    import bwmem_pkg::*;
(
    input  acc_size_e         size,
    input  logic              addr_lsb,
    input  logic              in_range,
    input  logic [7:0]        lo_byte,
    input  logic [7:0]        hi_byte,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] ptr_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ld_result,
    output logic [DATA_W-1:0] ptr_next
);
    localparam logic [DATA_W-1:0] STEP_BYTE = DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP_WORD = DATA_W'(LANES);

    logic [7:0]        sel_byte;
    logic [DATA_W-1:0] row_word;

    // Form the row word and the addressed byte, zero when out of range.
    always_comb begin
        row_word = in_range ? {hi_byte, lo_byte} : '0;
        sel_byte = addr_lsb ? row_word[15:8] : row_word[7:0];
    end

    // Drive the read path and the merged destination value.
    always_comb begin
        if (size == SZ_BYTE) begin
            rd_data   = {8'h00, sel_byte};
            ld_result = {dst_in[DATA_W-1:BYTE_W], sel_byte};
        end else begin
            rd_data   = row_word;
            ld_result = row_word;
        end
    end

    // Step the pointer by the access size.
    always_comb begin
        ptr_next = ptr_in + ((size == SZ_BYTE) ? STEP_BYTE : STEP_WORD);
    end
endmodule

// File: rtl/bwmem_fault.sv
// Module: alignment checker and trap generator. Flags a word access at an
// odd address in the same cycle, then latches the address and direction
// and pulses the trap for one cycle on the following clock.
module bwmem_fault
    import bwmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  acc_req_t          req,
    output logic              addr_err,
    output logic              trap_pulse,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_write
);
    // Detect a misaligned word access.
    always_comb begin
        addr_err = req.valid && (req.size == SZ_WORD) && req.addr[0];
    end

    // Register the trap and capture fault details.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse  <= 1'b0;
            fault_addr  <= '0;
            fault_write <= 1'b0;
        end else begin
            trap_pulse <= addr_err;
            if (addr_err) begin
                fault_addr  <= req.addr;
                fault_write <= req.write;
            end
        end
    end
endmodule

// File: rtl/bwmem_extend.sv
// Module: widens the low byte of a register to the full datapath, filling
// the upper bits with bit 7 (signed) or zero (unsigned). Purely combinational.
module bwmem_extend
    import bwmem_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic              sign_mode,
    output logic [DATA_W-1:0] dst
);
    logic fill;

    // Choose the fill bit for the upper byte.
    always_comb begin
        fill = sign_mode & src[BYTE_W-1];
    end

    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_bit
            if (b < BYTE_W) begin : g_keep
                assign dst[b] = src[b];
            end else begin : g_fill
                assign dst[b] = fill;
            end
        end
    endgenerate
endmodule

// File: rtl/bwmem_access_unit.sv
// Module: top of the byte/word data memory access unit. Decodes the
// address into a shared row index and per-bank write enables, suppresses
// misaligned word writes, and wires steering, fault and extension logic.
// Assumes MEM_BYTES is even and at least 2; addresses >= MEM_BYTES are empty.
module bwmem_access_unit
    import bwmem_pkg::*;
#(
    parameter int MEM_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_byte,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [15:0] dst_in,
    input  logic [15:0] ptr_in,
    input  logic [15:0] ext_src,
    input  logic        ext_sign,
    output logic [15:0] rd_data,
    output logic [15:0] ld_result,
    output logic [15:0] ptr_next,
    output logic [15:0] ext_out,
    output logic        addr_err,
    output logic        trap_pulse,
    output logic [15:0] fault_addr,
    output logic        fault_write
);
    localparam int ROWS  = MEM_BYTES / LANES;
    localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    acc_req_t         req;
    logic             in_range;
    logic [IDX_W-1:0] row_idx;
    logic [LANES-1:0] lane_we;
    logic [7:0]       lane_wbyte [LANES];
    logic [7:0]       lane_rbyte [LANES];

    // Pack the request into the shared record.
    always_comb begin
        req.valid = req_valid;
        req.write = req_write;
        req.size  = req_byte ? SZ_BYTE : SZ_WORD;
        req.addr  = req_addr;
    end

    // Decode range and shared row index.
    always_comb begin
        in_range = (32'(req_addr) < MEM_BYTES);
        row_idx  = in_range ? req_addr[IDX_W:1] : '0;
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Enable this bank for matching byte stores or aligned word stores.
            always_comb begin
                if (!(req_valid && req_write && in_range)) begin
                    lane_we[l] = 1'b0;
                end else if (req_byte) begin
                    lane_we[l] = (req_addr[0] == l[0]);
                end else begin
                    lane_we[l] = !req_addr[0];
                end
            end

            // Byte stores take the low datapath byte in every bank.
            always_comb begin
                lane_wbyte[l] = req_byte ? req_wdata[7:0] : req_wdata[l*8 +: 8];
            end

            bwmem_bank #(
                .ROWS  (ROWS),
                .IDX_W (IDX_W)
            ) u_bank (
                .clk   (clk),
                .we    (lane_we[l]),
                .widx  (row_idx),
                .wbyte (lane_wbyte[l]),
                .ridx  (row_idx),
                .rbyte (lane_rbyte[l])
            );
        end
    endgenerate

    bwmem_steer u_steer (
        .size      (req.size),
        .addr_lsb  (req_addr[0]),
        .in_range  (in_range),
        .lo_byte   (lane_rbyte[0]),
        .hi_byte   (lane_rbyte[1]),
        .dst_in    (dst_in),
        .ptr_in    (ptr_in),
        .rd_data   (rd_data),
        .ld_result (ld_result),
        .ptr_next  (ptr_next)
    );

    bwmem_fault u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .addr_err    (addr_err),
        .trap_pulse  (trap_pulse),
        .fault_addr  (fault_addr),
        .fault_write (fault_write)
    );

    bwmem_extend u_ext (
        .src       (ext_src),
        .sign_mode (ext_sign),
        .dst       (ext_out)
    );
endmodule

// File: rtl/bwmem_access_unit_chk.sv
// Module: property checker for the access unit, bound to every instance.
// Observes ports and the per-bank write enables; drives nothing.
module bwmem_access_unit_chk #(
    parameter int MEM_BYTES = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_byte,
    input logic [15:0] req_addr,
    input logic [15:0] dst_in,
    input logic [15:0] ptr_in,
    input logic [15:0] rd_data,
    input logic [15:0] ld_result,
    input logic [15:0] ptr_next,
    input logic        addr_err,
    input logic        trap_pulse,
    input logic [15:0] fault_addr,
    input logic        fault_write,
    input logic [1:0]  lane_we
);
    a_r2_byte_store_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_byte) |-> ($countones(lane_we) <= 1));

    a_r6_no_write_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_byte && req_addr[0]) |-> (lane_we == 2'b00));

    a_r7_trap_follows_error: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> trap_pulse);

    a_r7_trap_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_err |=> !trap_pulse);

    a_r7_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> (fault_addr == $past(req_addr) && fault_write == $past(req_write)));

    a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_err |=> ($stable(fault_addr) && $stable(fault_write)));

    a_r8_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (16'(ptr_next - ptr_in) == (req_byte ? 16'd1 : 16'd2)));

    a_r9_byte_load_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_byte) |-> (ld_result[15:8] == dst_in[15:8]));

    a_r11_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (32'(req_addr) >= MEM_BYTES)) |-> (rd_data == 16'h0000));

    a_r11_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(req_addr) >= MEM_BYTES) |-> (lane_we == 2'b00));
endmodule

bind bwmem_access_unit bwmem_access_unit_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_byte    (req_byte),
    .req_addr    (req_addr),
    .dst_in      (dst_in),
    .ptr_in      (ptr_in),
    .rd_data     (rd_data),
    .ld_result   (ld_result),
    .ptr_next    (ptr_next),
    .addr_err    (addr_err),
    .trap_pulse  (trap_pulse),
    .fault_addr  (fault_addr),
    .fault_write (fault_write),
    .lane_we     (lane_we)
);

// File: tb/bwmem_access_unit_test.sv
// Bench: sweeps every address of a 16-byte configuration (plus 16 empty
// addresses) through all access kinds against a byte-array model.
module bwmem_access_unit_test;
    localparam int NB   = 16;
    localparam int SPAN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, ext_sign = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, dst_in = '0, ptr_in = '0, ext_src = '0;
    logic [15:0] rd_data, ld_result, ptr_next, ext_out, fault_addr;
    logic        addr_err, trap_pulse, fault_write;

    logic [7:0]  model [SPAN];
    logic [15:0] m_faddr = '0;
    logic        m_fwr = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    bwmem_access_unit #(.MEM_BYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
        .dst_in(dst_in), .ptr_in(ptr_in), .ext_src(ext_src), .ext_sign(ext_sign),
        .rd_data(rd_data), .ld_result(ld_result), .ptr_next(ptr_next),
        .ext_out(ext_out), .addr_err(addr_err), .trap_pulse(trap_pulse),
        .fault_addr(fault_addr), .fault_write(fault_write)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] row_of(input int a);
        int b = a & ~1;
        return (b < NB) ? {model[b+1], model[b]} : 16'h0000;
    endfunction

    // One access: combinational checks before the edge, trap checks after it.
    task automatic access(input bit wr, input bit by, input int a,
                          input logic [15:0] wd, input logic [15:0] dst);
        logic [15:0] w;
        logic [7:0]  sb;
        bit          err;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = 16'(a);
        req_wdata = wd; dst_in = dst; ptr_in = 16'(a * 37 + 16'hFFF0);
        #1;
        err = !by && a[0];
        w   = row_of(a);
        sb  = a[0] ? w[15:8] : w[7:0];
        chk(err ? "R4 misaligned flag" : "R4 aligned no flag", 16'(addr_err), 16'(err));
        chk("R8 pointer step", ptr_next, 16'(ptr_in + (by ? 1 : 2)));
        if (!wr) begin
            if (by) begin
                chk(a >= NB ? "R11 empty byte read" : "R1 byte steer", rd_data, {8'h00, sb});
                chk("R9 byte load merge", ld_result, {dst[15:8], sb});
            end else begin
                chk(err ? "R5 misaligned read data" : "R3 word read", rd_data, w);
                chk("R9 word load", ld_result, w);
            end
        end
        @(posedge clk);
        if (wr && a < NB) begin
            if (by) model[a] = wd[7:0];
            else if (!err) begin model[a] = wd[7:0]; model[a+1] = wd[15:8]; end
        end
        if (err) begin m_faddr = 16'(a); m_fwr = wr; end
        #1;
        chk("R7 trap pulse", 16'(trap_pulse), 16'(err));
        chk("R7 fault addr", fault_addr, m_faddr);
        chk("R7 fault dir", 16'(fault_write), 16'(m_fwr));
    endtask

    task automatic verify_all();
        for (int a = 0; a < SPAN; a++) access(1'b0, 1'b1, a, 16'h0, 16'(16'hC300 + a));
    endtask

    initial begin
        for (int i = 0; i < SPAN; i++) model[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset trap", 16'(trap_pulse), 16'h0);
        chk("R12 reset fault addr", fault_addr, 16'h0);
        chk("R12 reset fault dir", 16'(fault_write), 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R3: aligned word stores everywhere (empty range included, R11)
        for (int a = 0; a < SPAN; a += 2) access(1'b1, 1'b0, a, 16'(a * 16'h0B13 + 16'h2A5C), 16'h0);
        for (int a = 0; a < SPAN; a++) access(1'b0, 1'b0, a, 16'h0, 16'h0);
        // R2: byte stores, odd then even lanes, with garbage in the high byte
        for (int a = 1; a < SPAN; a += 2) access(1'b1, 1'b1, a, 16'(16'hEE00 | (a * 7)), 16'h0);
        verify_all();
        for (int a = 0; a < SPAN; a += 2) access(1'b1, 1'b1, a, 16'(16'h5500 | (a * 11 + 3)), 16'h0);
        verify_all();
        // R6 with R7: back-to-back misaligned stores must leave memory unchanged
        for (int a = 1; a < SPAN; a += 2) access(1'b1, 1'b0, a, 16'hDEAD, 16'h0);
        verify_all();
        // R5 with R7: back-to-back misaligned reads, then mixed fault directions
        for (int a = 1; a < SPAN; a += 2) access(1'b0, 1'b0, a, 16'h0, 16'h1234);
        access(1'b1, 1'b0, 5, 16'hBEEF, 16'h0);
        access(1'b0, 1'b0, 7, 16'h0, 16'h0);
        access(1'b0, 1'b1, 3, 16'h0, 16'hFFFF);
        verify_all();

        // R10: every low byte, both modes, varying upper input bits
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                ext_src = 16'((v * 16'h0900) ^ 16'hA500) | 16'(v);
                ext_src[7:0] = 8'(v);
                ext_sign = s[0];
                #1;
                chk("R10 extend", ext_out,
                    {(s[0] && v[7]) ? 8'hFF : 8'h00, 8'(v)});
            end
        end

        // R12: reset after a fault clears the trap and fault registers
        access(1'b1, 1'b0, 9, 16'h0, 16'h0);
        @(negedge clk); req_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R12 reset clears fault addr", fault_addr, 16'h0);
        chk("R12 reset clears fault dir", 16'(fault_write), 16'h0);
        chk("R12 reset clears trap", 16'(trap_pulse), 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule